// File: doc/BRIEF.md
# Multi-Event Buffer Readout Sequencer

This block sits between a digitizer's acquisition logic and its bus slave. It holds a ring of event buffers. The acquisition side fills free buffers with complete events. At the same time a bus master drains the stored events through a single sequential read port. Writing continues while reading is in progress, so acquisition loses nothing until every buffer is occupied.

Reads inside the port's 4-kilobyte window ignore the address value and return the next word of the oldest stored event. Each event comes out whole, in this order:

- four header words: size, channel mask, trigger time tag and event counter;
- the channel samples, channel 0 first.

A buffer goes back to the free pool only after its last word has been read. An event therefore cannot be left half-read. In block-transfer mode the master programs an event count. Once that many events have been delivered, later reads are refused, either with a bus error or with a filler word.

Top module: `event_buffer_sequencer`

## Requirements
- R1: After reset, `full` is 0, `lost_cnt` is 0 and `rd_valid` is 0.
- R2: An event is returned in this order:
  - word 0: the size word;
  - word 1: the channel mask `32'h000000FF`;
  - word 2: the trigger time tag latched at `wr_start`;
  - word 3: the event counter;
  - then NUM_CH×CH_WORDS sample words, channel 0 first, in the order they were written.
- R3: The size word is `{4'hA, 28-bit event length in 32-bit words}`. The length is 4 + NUM_CH×CH_WORDS, which is 20 with the defaults. The event length in bytes is therefore 8×(NUM_CH×CH_WORDS/2)+16.
- R4: Any byte address below 0x1000 returns the next sequential word whatever its value. A read at 0x1000 or above gets no response (`rd_valid` stays 0) and does not advance the sequence.
- R5: Reading the last word of an event frees its buffer. The next read returns word 0 of the following stored event.
- R6: A read with no stored event returns `rd_valid`=1 and changes no pointer. The response is either the filler `32'hFEED0BAD` with `rd_berr`=0 (termination disabled) or `rd_berr`=1 (termination enabled).
- R7: `full` is 1 while all 8 buffers hold events. A `wr_start` while full is rejected, increments `lost_cnt`, and leaves the stored events intact. `full` clears once an event has been read out.
- R8: A write commit (`wr_end`) and the final read of another event in the same cycle are both honoured.
- R9: In block mode, once `blt_nev` events have been read since the last `blt_start`, further reads return `rd_berr`=1 (termination enabled) or the filler (termination disabled) without consuming data. A read with `blt_start` restarts the count.
- R10: The event counter is 0 for the first event after reset. It increments once per accepted event; rejected events do not count.
- R11: Every in-window read produces its response exactly one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Start of a new event |
| wr_ttt | input | 32 | Trigger time tag, sampled with `wr_start` |
| wr_valid | input | 1 | Sample word valid |
| wr_data | input | 32 | Sample word |
| wr_end | input | 1 | End of event; commits the buffer |
| full | output | 1 | All buffers occupied |
| lost_cnt | output | 16 | Number of rejected events |
| rd_req | input | 1 | Read request |
| rd_addr | input | 16 | Byte address of the read |
| blt_mode | input | 1 | Block-transfer mode enable |
| berr_en | input | 1 | Answer refused reads with a bus error |
| blt_start | input | 1 | Marks the first read of a block transfer |
| blt_nev | input | 8 | Events allowed per block transfer |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| rd_berr | output | 1 | Bus error response |

## Verification
The assertions assume a well-formed write handshake:

- `wr_start` is not repeated while an event is still being written;
- `wr_start` and `wr_end` never coincide;
- the number of sample pulses equals NUM_CH×CH_WORDS.

They also assume `blt_nev` stays constant during a transfer. The stimulus generates writes only through a task that issues exactly one start, the full sample count and one end. Random reads draw word-aligned addresses inside the window, and out-of-window addresses appear only in directed cases. Block-mode settings change only between transfers.

// File: rtl/evb_pkg.sv
package evb_pkg;
    localparam int         HDR_WORDS = 4;
    localparam logic [3:0] HDR_TAG   = 4'hA;
    localparam logic [31:0] FILLER   = 32'hFEED0BAD;
endpackage

// File: rtl/evb_ring.sv
module evb_ring #(
    parameter int NB  = 8,
    parameter int SW  = 16,
    parameter int LW  = 16,
    parameter int BW  = $clog2(NB),
    parameter int SIW = $clog2(SW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_start,
    input  logic           wr_valid,
    input  logic           wr_end,
    input  logic           rel,
    output logic [BW-1:0]  wr_ptr,
    output logic [BW-1:0]  rd_ptr,
    output logic           occ_nz,
    output logic           full,
    output logic [LW-1:0]  lost_cnt,
    output logic           hdr_we,
    output logic [31:0]    evcnt,
    output logic           mem_we,
    output logic [SIW-1:0] mem_widx
);
    localparam int OW = $clog2(NB + 1);

    typedef struct packed {
        logic [BW-1:0]  wptr;
        logic [BW-1:0]  rptr;
        logic [OW-1:0]  occ;
        logic [LW-1:0]  lost;
        logic           act;
        logic [SIW-1:0] widx;
        logic [31:0]    evc;
    } ring_t;

    ring_t q, d;
    logic  commit;

    always_comb begin
        d      = q;
        hdr_we = wr_start && !q.act && (q.occ != OW'(NB));
        mem_we = wr_valid && q.act && (q.widx < SIW'(SW));
        commit = wr_end && q.act;
        if (hdr_we) begin
            d.act  = 1'b1;
            d.widx = '0;
        end
        if (wr_start && !q.act && (q.occ == OW'(NB)))
            d.lost = q.lost + LW'(1);
        if (mem_we)
            d.widx = q.widx + SIW'(1);
        if (commit) begin
            d.act  = 1'b0;
            d.wptr = (q.wptr == BW'(NB - 1)) ? '0 : q.wptr + BW'(1);
            d.evc  = q.evc + 32'd1;
        end
        if (rel)
            d.rptr = (q.rptr == BW'(NB - 1)) ? '0 : q.rptr + BW'(1);
        d.occ = q.occ + OW'(commit) - OW'(rel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_ptr   = q.wptr;
    assign rd_ptr   = q.rptr;
    assign occ_nz   = (q.occ != '0);
    assign full     = (q.occ == OW'(NB));
    assign lost_cnt = q.lost;
    assign evcnt    = q.evc;
    assign mem_widx = q.widx;

    // R7: occupancy never exceeds the number of buffers
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.occ <= OW'(NB));
    // R7: a start while full is counted as lost
    p_full_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_start |=> lost_cnt == LW'($past(lost_cnt) + LW'(1)));
    // R6: the reader never frees a buffer when none is stored
    p_rel_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> occ_nz);
endmodule

// File: rtl/evb_store.sv
module evb_store #(
    parameter int NB  = 8,
    parameter int SW  = 16,
    parameter int BW  = $clog2(NB),
    parameter int SIW = $clog2(SW + 1)
) (
    input  logic           clk,
    input  logic           mem_we,
    input  logic [BW-1:0]  wbuf,
    input  logic [SIW-1:0] widx,
    input  logic [31:0]    wdata,
    input  logic           hdr_we,
    input  logic [31:0]    ttt_in,
    input  logic [31:0]    evc_in,
    input  logic [BW-1:0]  rbuf,
    input  logic [SIW-1:0] ridx,
    output logic [31:0]    samp,
    output logic [31:0]    ttt_o,
    output logic [31:0]    evc_o
);
    localparam int AW = $clog2(NB * SW);

    logic [31:0] mem   [NB*SW];
    logic [31:0] ttt_r [NB];
    logic [31:0] evc_r [NB];
    logic [AW-1:0] wa, ra;

    assign wa = AW'(int'(wbuf) * SW + int'(widx));
    assign ra = AW'(int'(rbuf) * SW + int'(ridx));

    always_ff @(posedge clk) begin
        if (mem_we) mem[wa] <= wdata;
        if (hdr_we) begin
            ttt_r[wbuf] <= ttt_in;
            evc_r[wbuf] <= evc_in;
        end
    end

    assign samp  = mem[ra];
    assign ttt_o = ttt_r[rbuf];
    assign evc_o = evc_r[rbuf];
endmodule

// File: rtl/evb_reader.sv
module evb_reader #(
    parameter int SW   = 16,
    parameter int NCH  = 8,
    parameter int AWD  = 16,
    parameter int WIN  = 4096,
    parameter int NW   = 8,
    parameter int SIW  = $clog2(SW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_req,
    input  logic [AWD-1:0] rd_addr,
    input  logic           blt_mode,
    input  logic           berr_en,
    input  logic           blt_start,
    input  logic [NW-1:0]  blt_nev,
    input  logic           occ_nz,
    input  logic [31:0]    samp,
    input  logic [31:0]    ttt,
    input  logic [31:0]    evc,
    output logic [SIW-1:0] sidx,
    output logic           rel,
    output logic           rd_valid,
    output logic [31:0]    rd_data,
    output logic           rd_berr
);
    import evb_pkg::*;
    localparam int EW  = SW + HDR_WORDS;
    localparam int RIW = $clog2(EW);

    typedef struct packed {
        logic [RIW-1:0] ridx;
        logic [NW-1:0]  bcnt;
        logic           vld;
        logic           berr;
        logic [31:0]    data;
    } rd_t;

    rd_t q, d;
    logic        hit, blocked, pop, last;
    logic [NW-1:0] bc;
    logic [31:0] word;

    always_comb begin
        sidx = (q.ridx >= RIW'(HDR_WORDS)) ? SIW'(q.ridx - RIW'(HDR_WORDS)) : '0;
        case (q.ridx)
            RIW'(0): word = {HDR_TAG, 28'(EW)};
            RIW'(1): word = 32'((64'd1 << NCH) - 64'd1);
            RIW'(2): word = ttt;
            RIW'(3): word = evc;
            default: word = samp;
        endcase
        hit     = rd_req && (rd_addr < AWD'(WIN));
        bc      = blt_start ? '0 : q.bcnt;
        blocked = blt_mode && (bc >= blt_nev);
        pop     = hit && occ_nz && !blocked;
        last    = (q.ridx == RIW'(EW - 1));
        rel     = pop && last;
        d       = q;
        d.vld   = hit;
        d.berr  = hit && !pop && berr_en;
        d.data  = pop ? word : (d.berr ? 32'h0 : FILLER);
        if (pop) d.ridx = last ? '0 : q.ridx + RIW'(1);
        d.bcnt  = (rel && blt_mode) ? bc + NW'(1) : bc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid = q.vld;
    assign rd_data  = q.data;
    assign rd_berr  = q.berr;

    // R11: in-window request answered on the next cycle
    p_resp_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && (rd_addr < AWD'(WIN)) |=> rd_valid);
    // R4: out-of-window request is silent and does not advance
    p_oow_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && (rd_addr >= AWD'(WIN)) |=> !rd_valid && $stable(q.ridx));
    // R9: a bus error is always a valid response
    p_berr_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_berr |-> rd_valid);
    // R9: no bus error when termination is disabled
    p_berr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_en |=> !rd_berr);
    // R2: word index stays inside one event
    p_ridx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.ridx < RIW'(EW));
endmodule

// File: rtl/event_buffer_sequencer.sv
module event_buffer_sequencer #(
    parameter int NUM_BUF   = 8,
    parameter int NUM_CH    = 8,
    parameter int CH_WORDS  = 2,
    parameter int ADDR_W    = 16,
    parameter int WIN_BYTES = 4096,
    parameter int BLT_W     = 8,
    parameter int LOST_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [31:0]       wr_ttt,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic              wr_end,
    output logic              full,
    output logic [LOST_W-1:0] lost_cnt,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              blt_mode,
    input  logic              berr_en,
    input  logic              blt_start,
    input  logic [BLT_W-1:0]  blt_nev,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              rd_berr
);
    localparam int SW  = NUM_CH * CH_WORDS;
    localparam int BW  = $clog2(NUM_BUF);
    localparam int SIW = $clog2(SW + 1);

    logic [BW-1:0]  wr_ptr, rd_ptr;
    logic           occ_nz, rel, hdr_we, mem_we;
    logic [31:0]    evcnt, samp, ttt_o, evc_o;
    logic [SIW-1:0] mem_widx, sidx;

    evb_ring #(.NB(NUM_BUF), .SW(SW), .LW(LOST_W), .BW(BW), .SIW(SIW)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_valid(wr_valid),
        .wr_end(wr_end), .rel(rel), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .occ_nz(occ_nz), .full(full), .lost_cnt(lost_cnt), .hdr_we(hdr_we),
        .evcnt(evcnt), .mem_we(mem_we), .mem_widx(mem_widx));

    evb_store #(.NB(NUM_BUF), .SW(SW), .BW(BW), .SIW(SIW)) u_store (
        .clk(clk), .mem_we(mem_we), .wbuf(wr_ptr), .widx(mem_widx),
        .wdata(wr_data), .hdr_we(hdr_we), .ttt_in(wr_ttt), .evc_in(evcnt),
        .rbuf(rd_ptr), .ridx(sidx), .samp(samp), .ttt_o(ttt_o), .evc_o(evc_o));

    evb_reader #(.SW(SW), .NCH(NUM_CH), .AWD(ADDR_W), .WIN(WIN_BYTES),
                 .NW(BLT_W), .SIW(SIW)) u_reader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .blt_mode(blt_mode), .berr_en(berr_en), .blt_start(blt_start),
        .blt_nev(blt_nev), .occ_nz(occ_nz), .samp(samp), .ttt(ttt_o),
        .evc(evc_o), .sidx(sidx), .rel(rel), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_berr(rd_berr));
endmodule

// File: tb/tb_event_buffer_sequencer.sv
module tb_event_buffer_sequencer;
    localparam int EW = 20;
    localparam int SW = 16;
    localparam logic [31:0] FILL = 32'hFEED0BAD;

    logic clk = 0, rst_n = 0;
    logic wr_start = 0, wr_valid = 0, wr_end = 0;
    logic [31:0] wr_ttt = 0, wr_data = 0;
    logic full; logic [15:0] lost_cnt;
    logic rd_req = 0, blt_mode = 0, berr_en = 0, blt_start = 0;
    logic [15:0] rd_addr = 0; logic [7:0] blt_nev = 0;
    logic rd_valid, rd_berr; logic [31:0] rd_data;

    int nchk = 0, nerr = 0, evn = 0, lost_exp = 0;
    bit done = 0;
    logic [31:0] q_ttt[$], q_cnt[$];

    always #4 clk = ~clk;

    event_buffer_sequencer dut (.*);

    function automatic logic [31:0] samp_val(input logic [31:0] cnt, input int k);
        return {8'h5A, cnt[11:0], 12'(k)};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] t, input logic [31:0] c, input int i);
        case (i)
            0: return {4'hA, 28'(EW)};
            1: return 32'h000000FF;
            2: return t;
            3: return c;
            default: return samp_val(c, i - 4);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic wr_begin(input logic [31:0] t);
        bit acc = (q_ttt.size() < 8);
        @(negedge clk); wr_start = 1; wr_ttt = t;
        @(negedge clk); wr_start = 0;
        for (int k = 0; k < SW; k++) begin
            wr_valid = 1; wr_data = samp_val(evn, k);
            @(negedge clk);
        end
        wr_valid = 0;
        if (acc) begin q_ttt.push_back(t); q_cnt.push_back(evn); evn++; end
        else lost_exp++;
    endtask

    task automatic wr_finish();
        wr_end = 1; @(negedge clk); wr_end = 0;
    endtask

    task automatic wr_event(input logic [31:0] t);
        wr_begin(t); wr_finish();
    endtask

    task automatic rd_word(input logic [15:0] a, input bit bs, output logic v,
                           output logic [31:0] dd, output logic b);
        @(negedge clk); rd_req = 1; rd_addr = a; blt_start = bs;
        @(negedge clk); rd_req = 0; blt_start = 0;
        v = rd_valid; dd = rd_data; b = rd_berr;
    endtask

    task automatic read_event(input string req, input bit bs, input int nwords);
        logic v, b; logic [31:0] dd, t, c, e;
        t = q_ttt.pop_front(); c = q_cnt.pop_front();
        for (int i = 0; i < nwords; i++) begin
            rd_word(16'($urandom % 1024) << 2, bs && (i == 0), v, dd, b);
            e = exp_word(t, c, i);
            chk(v && !b && dd == e, req, dd, e);
        end
        if (nwords < EW) begin q_ttt.push_front(t); q_cnt.push_front(c); end
    endtask

    initial begin
        #(8 * 150000);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic v, b; logic [31:0] dd;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(full == 0, "R1 full", 32'(full), 0);
        chk(lost_cnt == 0, "R1 lost_cnt", 32'(lost_cnt), 0);
        chk(rd_valid == 0, "R1 rd_valid", 32'(rd_valid), 0);

        // R6: empty reads
        rd_word(16'h0, 0, v, dd, b);
        chk(v && !b && dd == FILL, "R6 filler / R11 latency", dd, FILL);
        berr_en = 1;
        rd_word(16'h0, 0, v, dd, b);
        chk(v && b, "R6 berr on empty", 32'(b), 1);
        berr_en = 0;

        // R2 R3 R4 R5: two events, out-of-window read in between
        wr_event(32'h1111_0000);
        wr_event(32'h2222_0000);
        rd_word(16'h0FFC, 0, v, dd, b);
        chk(dd == {4'hA, 28'd20}, "R3 size word", dd, {4'hA, 28'd20});
        q_ttt.push_front(32'h1111_0000); // keep queue shape: consume word0 manually
        void'(q_ttt.pop_front());
        for (int i = 1; i < 6; i++) begin
            rd_word(16'(i * 4 + 8), 0, v, dd, b);
            chk(dd == exp_word(q_ttt[0], q_cnt[0], i), "R2 order", dd, exp_word(q_ttt[0], q_cnt[0], i));
        end
        rd_word(16'h1000, 0, v, dd, b);
        chk(v == 0, "R4 out of window silent", 32'(v), 0);
        rd_word(16'h0123, 0, v, dd, b);
        chk(dd == exp_word(q_ttt[0], q_cnt[0], 6), "R4 no advance", dd, exp_word(q_ttt[0], q_cnt[0], 6));
        for (int i = 7; i < EW; i++) begin
            rd_word(16'h0800, 0, v, dd, b);
            chk(dd == exp_word(q_ttt[0], q_cnt[0], i), "R2 samples", dd, exp_word(q_ttt[0], q_cnt[0], i));
        end
        void'(q_ttt.pop_front()); void'(q_cnt.pop_front());
        read_event("R5 next header R10", 0, EW);

        // R6: pointers unchanged by empty read
        rd_word(16'h0, 0, v, dd, b);
        chk(dd == FILL, "R6 empty again", dd, FILL);
        wr_event(32'h3333_0000);
        read_event("R6 after empty", 0, EW);

        // R7: fill all buffers
        for (int i = 0; i < 8; i++) wr_event(32'h100 + 32'(i));
        chk(full == 1, "R7 full set", 32'(full), 1);
        wr_event(32'hBAD0_0000);
        chk(lost_cnt == 16'(lost_exp), "R7 lost count", 32'(lost_cnt), 32'(lost_exp));
        chk(full == 1, "R7 still full", 32'(full), 1);
        read_event("R7 intact R10", 0, EW);
        chk(full == 0, "R7 full clears", 32'(full), 0);
        for (int i = 0; i < 7; i++) read_event("R7 R10 contents", 0, EW);

        // R8: commit and final read in the same cycle
        wr_event(32'hAAAA_0000);
        wr_begin(32'hBBBB_0000);
        read_event("R8 first words", 0, EW - 1);
        @(negedge clk); rd_req = 1; rd_addr = 16'h0; wr_end = 1;
        @(negedge clk); rd_req = 0; wr_end = 0;
        chk(rd_data == exp_word(q_ttt[0], q_cnt[0], EW - 1), "R8 last word", rd_data,
            exp_word(q_ttt[0], q_cnt[0], EW - 1));
        void'(q_ttt.pop_front()); void'(q_cnt.pop_front());
        read_event("R8 committed event", 0, EW);
        rd_word(16'h0, 0, v, dd, b);
        chk(dd == FILL, "R8 empty after", dd, FILL);

        // R9: block transfer termination
        blt_mode = 1; berr_en = 1; blt_nev = 2;
        for (int i = 0; i < 3; i++) wr_event(32'hC000_0000 + 32'(i));
        read_event("R9 block ev1", 1, EW);
        read_event("R9 block ev2", 0, EW);
        rd_word(16'h0, 0, v, dd, b);
        chk(v && b, "R9 berr after N", 32'(b), 1);
        berr_en = 0;
        rd_word(16'h0, 0, v, dd, b);
        chk(v && !b && dd == FILL, "R9 filler after N", dd, FILL);
        read_event("R9 restart", 1, EW);
        blt_mode = 0;

        // random mix
        for (int op = 0; op < 300; op++) begin
            if (($urandom % 2) == 0) wr_event($urandom);
            else if (q_ttt.size() > 0) read_event("R2 R5 R10 random", 0, EW);
        end
        chk(full == (q_ttt.size() == 8), "R7 random full", 32'(full), 32'(q_ttt.size() == 8));
        chk(lost_cnt == 16'(lost_exp), "R7 random lost", 32'(lost_cnt), 32'(lost_exp));
        while (q_ttt.size() > 0) read_event("R5 drain", 0, EW);
        rd_word(16'h0, 0, v, dd, b);
        chk(dd == FILL, "R6 final empty", dd, FILL);
        finish_run();
    end
endmodule